// File: doc/BRIEF.md
# Double-Buffered Clocked Serial Transceiver

This block moves bytes in and out over a three-wire clocked serial link: a data line out, a data line in and a shift clock shared by both directions. A host writes a byte into a holding buffer. The block moves that byte into a transmit shift register and sends it least significant bit first. In the same shift clock period it collects a byte from the input line into a receive shift register. A completed received byte is copied into a receive buffer that the host reads.

The shift clock comes from one of two places. The first is an internal divider: an optional divide-by-four prescaler, then a reloadable divide-by-(n+1) counter, then a toggle stage. The second is an external clock pin, brought in through a synchronizer. Status flags report whether the holding buffer is free, whether the shifter is idle, whether a received byte is waiting and whether one was lost. A host that refills the buffer before the current byte ends gets a continuous stream with no pause in the clock. An active-low ready output tells the link partner that a transfer is armed.

Top module: `sxfer_top`

## Requirements
- R1: After reset, tbe=1, tsc=1, rbf=0, ovr=0, txd=1, sck_out=1, rdy_n=1, tx_irq=0 and rx_irq=0.
- R2: A write (wr_en) clears tbe in the next cycle. If the shifter is idle (tsc=1), the cycle after that moves the buffer into the shifter, sets tbe and clears tsc.
- R3: With the internal clock, every half period of sck_out lasts P*(n+1) clk cycles. P is 4 when pre_sel=1 and 1 otherwise, and n is the last value written with brg_wr. sck_out rests high while tsc=1.
- R4: Data leaves on txd least significant bit first. txd changes only on a falling shift-clock edge. rxd is sampled on the rising edge.
- R5: After the 8th rising edge, if the buffer holds nothing new, tsc returns to 1 and the internal clock stops high.
- R6: If the buffer is written before the 8th rising edge of the current byte, the next byte follows at once. The half period does not change and tsc stays 0.
- R7: tx_irq is a one-cycle pulse. With txirq_sel=0 it pulses when tbe goes from 0 to 1. With txirq_sel=1 it pulses when tsc goes from 0 to 1.
- R8: When a byte completes with rx_en=1 and rbf=0, the byte appears on rd_data, rbf is set and rx_irq pulses in the same cycle. rd_en clears rbf in the next cycle.
- R9: When a byte completes with rbf=1, ovr is set, rd_data keeps the earlier byte and rx_irq does not pulse. rd_en clears ovr.
- R10: rdy_n goes low when a transfer starts from idle with rx_en=1. It returns high on the first falling shift-clock edge.
- R11: With ext_clk_sel=1, shifting follows the falling and rising edges of sck_in after a two-stage synchronizer, and sck_out stays high.
- R12: With rx_en=0, completed bytes are not stored (rbf stays 0) and rdy_n stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the transmit buffer |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Read strobe; clears rbf and ovr |
| rd_data | output | 8 | Receive buffer contents |
| brg_wr | input | 1 | Write strobe for the divider reload value |
| brg_data | input | 8 | Divider reload value n |
| ext_clk_sel | input | 1 | 1 selects the external shift clock |
| pre_sel | input | 1 | 1 inserts the divide-by-four prescaler |
| txirq_sel | input | 1 | Transmit interrupt source: 0 buffer empty, 1 shift complete |
| rx_en | input | 1 | Receiver enable |
| sck_in | input | 1 | External shift clock |
| sck_out | output | 1 | Internally generated shift clock |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |
| rdy_n | output | 1 | Active-low ready-to-receive handshake |
| tbe | output | 1 | Transmit buffer empty |
| tsc | output | 1 | Transmit shift complete |
| rbf | output | 1 | Receive buffer full |
| ovr | output | 1 | Overrun error |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The bench sweeps both prescaler settings across several reload values and measures every half period of the shift clock. A divider that is off by one, or that ignores the prescaler, shows up as a wrong interval. A byte queued during a transfer is checked for a seamless follow-on: a design that goes idle between the two bytes lengthens one interval and raises tsc after eight bits. The same two-byte run exposes an overrun that overwrites the first byte or that still raises a receive interrupt. Separate runs check the interrupt-source select, the gated receiver and the external clock path, which catch a wrong interrupt edge, a ready signal that never drops, and edges taken from the wrong source.

// File: rtl/sxfer_pkg.sv
package sxfer_pkg;
  // Single-cycle shift-clock edge strobes.
  typedef struct packed {
    logic fall;
    logic rise;
  } sx_edge_t;
endpackage

// File: rtl/sxfer_baud.sv
module sxfer_baud #(
  parameter int RW      = 8,
  parameter int PRE_DIV = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          pre_en,
  input  logic [RW-1:0] reload,
  output logic          tick
);
  localparam int PCW = $clog2(PRE_DIV);

  logic [PCW-1:0] pre_cnt;
  logic [RW-1:0]  div_cnt;
  logic           pre_done;

  always_comb pre_done = !pre_en || (pre_cnt == PCW'(PRE_DIV - 1));
  always_comb tick     = run && pre_done && (div_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_cnt <= '0;
      div_cnt <= reload;
    end else if (pre_done) begin
      pre_cnt <= '0;
      div_cnt <= (div_cnt == '0) ? reload : div_cnt - RW'(1);
    end else begin
      pre_cnt <= pre_cnt + PCW'(1);
    end
  end
endmodule

// File: rtl/sxfer_clksel.sv
module sxfer_clksel
  import sxfer_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     ext_sel,
  input  logic     active,
  input  logic     tick,
  input  logic     sck_in,
  output sx_edge_t edg,
  output logic     sck_out
);
  logic [SYNC:0] sh;
  logic          ext_fall, ext_rise;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[SYNC-1:0], sck_in};
  end

  always_comb begin
    ext_fall = sh[SYNC] && !sh[SYNC-1];
    ext_rise = !sh[SYNC] && sh[SYNC-1];
  end

  always_ff @(posedge clk) begin
    if (rst || !active || ext_sel) sck_out <= 1'b1;
    else if (tick)                 sck_out <= !sck_out;
  end

  always_comb begin
    if (ext_sel) begin
      edg.fall = active && ext_fall;
      edg.rise = active && ext_rise;
    end else begin
      edg.fall = tick && sck_out;
      edg.rise = tick && !sck_out;
    end
  end
endmodule

// File: rtl/sxfer_top.sv
module sxfer_top
  import sxfer_pkg::*;
#(
  parameter int DW      = 8,
  parameter int RW      = 8,
  parameter int PRE_DIV = 4,
  parameter int SYNC    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          brg_wr,
  input  logic [RW-1:0] brg_data,
  input  logic          ext_clk_sel,
  input  logic          pre_sel,
  input  logic          txirq_sel,
  input  logic          rx_en,
  input  logic          sck_in,
  output logic          sck_out,
  output logic          txd,
  input  logic          rxd,
  output logic          rdy_n,
  output logic          tbe,
  output logic          tsc,
  output logic          rbf,
  output logic          ovr,
  output logic          tx_irq,
  output logic          rx_irq
);
  localparam int BCW = $clog2(DW);

  logic [DW-1:0]  tbuf, tsr, rsr;
  logic [RW-1:0]  brg_q;
  logic [BCW-1:0] bit_cnt;
  logic           tick, sh_fall;
  sx_edge_t       edg;

  logic load_idle, last_rise, do_load, done_idle, rbf_hold, rx_store, rx_over;

  sxfer_baud #(.RW(RW), .PRE_DIV(PRE_DIV)) u_baud (
    .clk(clk), .rst(rst), .run(!tsc && !ext_clk_sel), .pre_en(pre_sel),
    .reload(brg_q), .tick(tick)
  );

  sxfer_clksel #(.SYNC(SYNC)) u_clk (
    .clk(clk), .rst(rst), .ext_sel(ext_clk_sel), .active(!tsc),
    .tick(tick), .sck_in(sck_in), .edg(edg), .sck_out(sck_out)
  );

  always_comb begin
    sh_fall   = edg.fall;
    load_idle = tsc && !tbe;
    last_rise = edg.rise && (bit_cnt == BCW'(DW - 1));
    do_load   = load_idle || (last_rise && !tbe);
    done_idle = last_rise && tbe;
    rbf_hold  = rbf && !rd_en;
    rx_store  = last_rise && rx_en && !rbf_hold;
    rx_over   = last_rise && rx_en && rbf_hold;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tbuf    <= '0;
      tsr     <= '0;
      rsr     <= '0;
      rd_data <= '0;
      brg_q   <= '0;
      bit_cnt <= '0;
      tbe     <= 1'b1;
      tsc     <= 1'b1;
      rbf     <= 1'b0;
      ovr     <= 1'b0;
      txd     <= 1'b1;
      rdy_n   <= 1'b1;
      tx_irq  <= 1'b0;
      rx_irq  <= 1'b0;
    end else begin
      tx_irq <= txirq_sel ? done_idle : (do_load && !wr_en);
      rx_irq <= rx_store;
      if (brg_wr) brg_q <= brg_data;
      if (edg.fall) begin
        txd   <= tsr[0];
        tsr   <= tsr >> 1;
        rdy_n <= 1'b1;
      end
      if (edg.rise) begin
        rsr     <= {rxd, rsr[DW-1:1]};
        bit_cnt <= last_rise ? '0 : bit_cnt + BCW'(1);
      end
      if (do_load) begin
        tsr <= tbuf;
        tbe <= 1'b1;
        tsc <= 1'b0;
      end
      if (load_idle) rdy_n <= !rx_en;
      if (done_idle) tsc <= 1'b1;
      if (wr_en) begin
        tbuf <= wr_data;
        tbe  <= 1'b0;
      end
      if (rd_en) begin
        rbf <= 1'b0;
        ovr <= 1'b0;
      end
      if (rx_store) begin
        rd_data <= {rxd, rsr[DW-1:1]};
        rbf     <= 1'b1;
      end
      if (rx_over) ovr <= 1'b1;
    end
  end
endmodule

// File: rtl/sxfer_chk.sv
module sxfer_chk (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic tbe,
  input logic tsc,
  input logic rbf,
  input logic ovr,
  input logic tx_irq,
  input logic rx_irq,
  input logic txirq_sel,
  input logic rdy_n,
  input logic sck_out,
  input logic txd,
  input logic sh_fall
);
  assert_wr_clears_tbe_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !tbe);

  assert_txirq_source_R7: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> ($past(txirq_sel) ? tsc : tbe));

  assert_rxirq_with_flag_R8: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> rbf);

  assert_rbf_rise_irq_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(rbf) |-> rx_irq);

  assert_ovr_needs_full_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr) |-> rbf);

  assert_idle_clock_high_R3: assert property (@(posedge clk) disable iff (rst)
    tsc |-> sck_out);

  assert_txd_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    !sh_fall |=> $stable(txd));

  assert_ready_only_busy_R10: assert property (@(posedge clk) disable iff (rst)
    !rdy_n |-> !tsc);
endmodule

bind sxfer_top sxfer_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .tbe(tbe), .tsc(tsc), .rbf(rbf),
  .ovr(ovr), .tx_irq(tx_irq), .rx_irq(rx_irq), .txirq_sel(txirq_sel),
  .rdy_n(rdy_n), .sck_out(sck_out), .txd(txd), .sh_fall(sh_fall)
);

// File: tb/sxfer_top_tb.sv
`timescale 1ns/1ps
module sxfer_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, rd_en = 0, brg_wr = 0;
  logic [7:0] wr_data = 0, brg_data = 0, rd_data;
  logic ext_clk_sel = 0, pre_sel = 0, txirq_sel = 0, rx_en = 1;
  logic sck_in = 1, sck_out, txd, rxd, rdy_n;
  logic tbe, tsc, rbf, ovr, tx_irq, rx_irq;
  logic ext_mode = 0, rxd_drv = 1;

  always #2 clk = !clk;
  assign rxd = ext_mode ? rxd_drv : txd;

  sxfer_top dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .brg_wr(brg_wr), .brg_data(brg_data),
    .ext_clk_sel(ext_clk_sel), .pre_sel(pre_sel), .txirq_sel(txirq_sel),
    .rx_en(rx_en), .sck_in(sck_in), .sck_out(sck_out), .txd(txd), .rxd(rxd),
    .rdy_n(rdy_n), .tbe(tbe), .tsc(tsc), .rbf(rbf), .ovr(ovr),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // Shift-clock monitor: half-period lengths and txd captured at rising edges.
  int cyc = 0, last_t = 0, exp_half = 1, bad_iv = 0, nb = 0, n_rxirq = 0;
  bit mon_on = 0, have_last = 0;
  logic sck_prev = 1'b1;
  logic [31:0] cap = 0;

  always @(negedge clk) begin
    cyc++;
    if (sck_out !== sck_prev) begin
      if (mon_on && have_last && (cyc - last_t) != exp_half) bad_iv++;
      if (mon_on) begin
        have_last = 1;
        last_t = cyc;
        if (sck_out && nb < 32) begin
          cap[nb] = txd;
          nb++;
        end
      end
    end
    if (rx_irq) n_rxirq++;
    sck_prev = sck_out;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk); wr_en = 1; wr_data = b;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_pulse();
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic set_brg(input logic [7:0] v);
    @(negedge clk); brg_wr = 1; brg_data = v;
    @(negedge clk); brg_wr = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (tsc) break;
    end
  endtask

  task automatic start_burst();
    nb = 0; have_last = 0; n_rxirq = 0; bad_iv = 0; cap = 0; mon_on = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 tbe", tbe, 1); chk("R1 tsc", tsc, 1); chk("R1 rbf", rbf, 0);
    chk("R1 ovr", ovr, 0); chk("R1 txd", txd, 1); chk("R1 sck_out", sck_out, 1);
    chk("R1 rdy_n", rdy_n, 1); chk("R1 tx_irq", tx_irq, 0); chk("R1 rx_irq", rx_irq, 0);

    // Sweep of prescaler and reload values with loopback (R2..R5, R7, R8, R10)
    for (int p = 0; p < 2; p++) begin
      for (int ni = 0; ni < 5; ni++) begin
        int n;
        logic [7:0] b;
        n = (ni < 4) ? ni : 7;
        b = 8'(n * 37 + p * 91 + 90);
        pre_sel = p[0];
        set_brg(8'(n));
        exp_half = (p == 1 ? 4 : 1) * (n + 1);
        start_burst();
        wr_byte(b);
        chk("R2 tbe after write", tbe, 0);
        chk("R2 tsc before load", tsc, 1);
        @(negedge clk);
        chk("R2 tbe after load", tbe, 1);
        chk("R2 tsc after load", tsc, 0);
        chk("R7 tx_irq on tbe rise", tx_irq, 1);
        chk("R10 rdy_n low at start", rdy_n, 0);
        while (sck_out) @(negedge clk);
        chk("R10 rdy_n high after first fall", rdy_n, 1);
        wait_idle();
        chk("R5 tsc set", tsc, 1);
        chk("R5 clock stops high", sck_out, 1);
        chk("R7 no tx_irq on tsc rise when sel=0", tx_irq, 0);
        @(negedge clk);
        chk("R3 half period", bad_iv, 0);
        chk("R4 bit count", nb, 8);
        chk("R4 lsb-first bits", cap[7:0], b);
        chk("R8 rbf", rbf, 1);
        chk("R8 rd_data", rd_data, b);
        chk("R8 rx_irq pulses", n_rxirq, 1);
        rd_pulse();
        chk("R8 rbf cleared by read", rbf, 0);
      end
    end

    // R7 transmit interrupt on shift complete
    txirq_sel = 1; pre_sel = 0; set_brg(8'd1); exp_half = 2;
    start_burst();
    wr_byte(8'h3C);
    @(negedge clk);
    chk("R7 no tx_irq on tbe rise when sel=1", tx_irq, 0);
    wait_idle();
    chk("R7 tx_irq on tsc rise", tx_irq, 1);
    @(negedge clk);
    chk("R7 tx_irq single cycle", tx_irq, 0);
    rd_pulse();
    txirq_sel = 0;

    // R6 gapless back-to-back bytes, R9 overrun on the second byte
    pre_sel = 1; set_brg(8'd2); exp_half = 12;
    start_burst();
    wr_byte(8'hA5);
    @(negedge clk);
    wr_byte(8'h1E);
    chk("R6 tbe held by queued byte", tbe, 0);
    wait_idle();
    @(negedge clk);
    chk("R6 sixteen bits without idle", nb, 16);
    chk("R6 no change in half period", bad_iv, 0);
    chk("R6 stream contents", cap[15:0], 16'h1EA5);
    chk("R9 ovr set", ovr, 1);
    chk("R9 rd_data keeps first byte", rd_data, 8'hA5);
    chk("R9 only one rx_irq", n_rxirq, 1);
    rd_pulse();
    chk("R9 ovr cleared by read", ovr, 0);
    chk("R9 rbf cleared by read", rbf, 0);

    // R12 receiver disabled
    rx_en = 0; pre_sel = 0; set_brg(8'd0); exp_half = 1;
    start_burst();
    wr_byte(8'h81);
    @(negedge clk);
    chk("R12 rdy_n stays high", rdy_n, 1);
    wait_idle();
    @(negedge clk);
    chk("R12 rbf stays clear", rbf, 0);
    chk("R12 no rx_irq", n_rxirq, 0);
    rx_en = 1;

    // R11 external shift clock
    mon_on = 0;
    ext_clk_sel = 1; ext_mode = 1;
    wr_byte(8'hC3);
    @(negedge clk);
    begin
      logic [7:0] pat, ecap;
      pat = 8'h6D; ecap = 0;
      for (int i = 0; i < 8; i++) begin
        sck_in = 0; rxd_drv = pat[i];
        repeat (8) @(negedge clk);
        ecap[i] = txd;
        if (i == 3) chk("R11 sck_out held high", sck_out, 1);
        sck_in = 1;
        repeat (8) @(negedge clk);
      end
      chk("R11 tsc after eight edges", tsc, 1);
      chk("R11 transmitted bits", ecap, 8'hC3);
      chk("R11 received byte", rd_data, pat);
      chk("R11 rbf", rbf, 1);
    end
    summary();
  end
endmodule